// File: doc/BRIEF.md
# Trial-Division Prime Sequence Generator

This block produces the prime numbers in increasing order, one at a time, on a valid/ready output. It spends clock cycles instead of area. The block puts out 2 and 3 directly. It then walks candidate values of the form 6k-1 and 6k+1, so that even numbers and multiples of three are never tried. Each candidate is tested against trial divisors that follow the same 6k±1 pattern, starting at 5. One shared multi-cycle shift-subtract divider serves every trial.

The test of a candidate ends when the square of the divisor exceeds the candidate, and no square-root unit is used. A zero remainder rejects the candidate. After each accepted prime the engine waits for a parameterised number of cycles before it resumes the search. This gives a slow consumer, such as a display, time to show the value. When the next candidate would pass the parameterised maximum value, the engine raises a sticky done flag and stops producing output. The maximum value sets every datapath width.

Top module: `prime_seq_gen`

## Requirements
- R1: The first value after reset is 2, and the second value is 3. The value 2 is on `out_prime` with `out_valid` high in the first cycle after reset is released.
- R2: The accepted values are exactly the primes from 2 up to `MAX_VAL`, in strictly increasing order. Each prime appears once, and no other value appears.
- R3: A candidate that is the square of a prime is rejected. The search must not stop on a divisor whose square equals the candidate. Examples are 25, 49, 121 and 169.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_prime` keeps its value.
- R5: After each accepted value, `out_valid` is low for at least `HOLD_CYCLES` cycles. Between the values 2 and 3 it is low for exactly `HOLD_CYCLES` cycles.
- R6: When the next candidate would exceed `MAX_VAL`, `done` rises after the last prime has been accepted. It then stays high, and `out_valid` stays low.
- R7: While `rst_n` is low, `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| out_ready | input | 1 | The consumer accepts the presented prime in this cycle |
| out_valid | output | 1 | A prime is presented on `out_prime` |
| out_prime | output | $clog2(MAX_VAL+1) | The prime value presented |
| done | output | 1 | The sequence has reached `MAX_VAL` (sticky) |

## Verification
The scoreboard compares every accepted value against a list of primes that the bench computes itself. This list includes the squares of primes, where a stopping test written as greater-or-equal would wrongly pass 25 or 49 as prime. A wrong step in the wheel or in the divisor sequence would skip a prime or let a composite through, and the scoreboard would show a missing or an extra entry. Irregular backpressure checks that a stalled output neither changes nor drops a value. The gap checks catch a hold timer that is off by one. The end of the run checks that `done` rises only after 199 has been accepted, and that no value appears after it.

// File: rtl/prime_seq_pkg.sv
package prime_seq_pkg;

    typedef enum logic [2:0] {
        ST_EMIT = 3'd0,
        ST_HOLD = 3'd1,
        ST_TEST = 3'd2,
        ST_DIV  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/prime_rem_div.sv
// Restoring shift-subtract divider that keeps only the remainder.
// One quotient bit per cycle; done_o pulses one cycle after the last step.
module prime_rem_div #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] rem_o
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  dvd;
        logic [W-1:0]  dvs;
    } div_regs_t;

    div_regs_t div_d, div_q;
    logic [W:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = '0;
        if (start_i) begin
            div_d.busy = 1'b1;
            div_d.cnt  = '0;
            div_d.rem  = '0;
            div_d.dvd  = dividend_i;
            div_d.dvs  = divisor_i;
        end else if (div_q.busy) begin
            trial = {div_q.rem, div_q.dvd[W-1]};
            if (trial >= {1'b0, div_q.dvs}) begin
                trial = trial - {1'b0, div_q.dvs};
            end
            div_d.rem = trial[W-1:0];
            div_d.dvd = div_q.dvd << 1;
            div_d.cnt = div_q.cnt + 1'b1;
            if (div_q.cnt == CW'(W - 1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign done_o = div_q.done;
    assign rem_o  = div_q.rem;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < div_q.dvs)); // R2

endmodule

// File: rtl/prime_hold_timer.sv
// Counts the post-emit hold window; expire_o marks its last cycle.
module prime_hold_timer #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o
);

    generate
        if (HOLD == 0) begin : g_no_hold
            logic unused_q;
            always_ff @(posedge clk) begin
                if (!rst_n) unused_q <= 1'b0;
                else        unused_q <= start_i;
            end
            assign expire_o = 1'b0 & unused_q;
        end else begin : g_hold
            localparam int HW = $clog2(HOLD + 1);
            logic [HW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (start_i) begin
                    cnt_d = HW'(HOLD);
                end else if (cnt_q != '0) begin
                    cnt_d = cnt_q - 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expire_o = (cnt_q == HW'(1));
        end
    endgenerate

endmodule

// File: rtl/prime_seq_gen.sv
module prime_seq_gen #(
    parameter int MAX_VAL     = 1000,
    parameter int HOLD_CYCLES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         out_ready,
    output logic                         out_valid,
    output logic [$clog2(MAX_VAL+1)-1:0] out_prime,
    output logic                         done
);
    import prime_seq_pkg::*;

    localparam int W  = $clog2(MAX_VAL + 1);
    localparam int W2 = 2 * W;

    typedef struct packed {
        seq_state_e   state;
        logic [W-1:0] prime;
        logic [W-1:0] cand;
        logic         cstep4;
        logic [W-1:0] dvs;
        logic         dstep4;
        logic         done;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic          div_start, div_done;
    logic [W-1:0]  div_rem;
    logic          tmr_start, tmr_expire;
    logic [W:0]    cand_nxt;
    logic          cand_over;
    logic [W2-1:0] dvs_sq;
    logic          after_emit, reject;

    prime_rem_div #(.W(W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(seq_q.cand),
        .divisor_i (seq_q.dvs),
        .done_o    (div_done),
        .rem_o     (div_rem)
    );

    prime_hold_timer #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (tmr_start),
        .expire_o(tmr_expire)
    );

    always_comb begin
        seq_d      = seq_q;
        div_start  = 1'b0;
        tmr_start  = 1'b0;
        after_emit = 1'b0;
        reject     = 1'b0;
        cand_nxt   = {1'b0, seq_q.cand} + (seq_q.cstep4 ? (W+1)'(4) : (W+1)'(2));
        cand_over  = cand_nxt > (W+1)'(MAX_VAL);
        dvs_sq     = W2'(seq_q.dvs) * W2'(seq_q.dvs);

        case (seq_q.state)
            ST_EMIT: begin
                if (out_ready) begin
                    if (HOLD_CYCLES == 0) begin
                        after_emit = 1'b1;
                    end else begin
                        tmr_start   = 1'b1;
                        seq_d.state = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (tmr_expire) after_emit = 1'b1;
            end
            ST_TEST: begin
                // strict compare: a divisor whose square equals the candidate is still tried
                if (dvs_sq > W2'(seq_q.cand)) begin
                    seq_d.prime = seq_q.cand;
                    seq_d.state = ST_EMIT;
                end else begin
                    div_start   = 1'b1;
                    seq_d.state = ST_DIV;
                end
            end
            ST_DIV: begin
                if (div_done) begin
                    if (div_rem == '0) begin
                        reject = 1'b1;
                    end else begin
                        seq_d.dvs    = seq_q.dvs + (seq_q.dstep4 ? W'(4) : W'(2));
                        seq_d.dstep4 = !seq_q.dstep4;
                        seq_d.state  = ST_TEST;
                    end
                end
            end
            default: begin
                seq_d.state = ST_DONE;
            end
        endcase

        if (after_emit) begin
            if (seq_q.prime == W'(2)) begin
                seq_d.prime = W'(3);
                seq_d.state = ST_EMIT;
            end else if (seq_q.prime == W'(3)) begin
                seq_d.cand   = W'(5);
                seq_d.cstep4 = 1'b0;
                seq_d.dvs    = W'(5);
                seq_d.dstep4 = 1'b0;
                seq_d.state  = ST_TEST;
            end else begin
                reject = 1'b1;
            end
        end

        if (reject) begin
            if (cand_over) begin
                seq_d.state = ST_DONE;
                seq_d.done  = 1'b1;
            end else begin
                seq_d.cand   = cand_nxt[W-1:0];
                seq_d.cstep4 = !seq_q.cstep4;
                seq_d.dvs    = W'(5);
                seq_d.dstep4 = 1'b0;
                seq_d.state  = ST_TEST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q        <= '0;
            seq_q.state  <= ST_EMIT;
            seq_q.prime  <= W'(2);
            seq_q.cand   <= W'(5);
            seq_q.dvs    <= W'(5);
        end else begin
            seq_q <= seq_d;
        end
    end

    assign out_valid = (seq_q.state == ST_EMIT);
    assign out_prime = seq_q.prime;
    assign done      = seq_q.done;

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_prime))); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R6
    AST_DONE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R6
    AST_WHEEL_RESIDUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_prime > W'(3)) |-> (out_prime[0] && (out_prime % W'(3) != '0))); // R2

endmodule

// File: tb/tb_prime_seq_gen.sv
module tb_prime_seq_gen;

    localparam int MAX_VAL = 200;
    localparam int HOLD    = 3;
    localparam int W       = $clog2(MAX_VAL + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         out_ready = 1'b0;
    logic         out_valid;
    logic [W-1:0] out_prime;
    logic         done;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_q[$];
    int n_accepted = 0;
    int squares_seen = 0;
    bit run_live = 1'b0;

    always #10 clk = ~clk;

    prime_seq_gen #(.MAX_VAL(MAX_VAL), .HOLD_CYCLES(HOLD)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_prime(out_prime),
        .done     (done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit is_prime(input int n);
        if (n < 2) return 1'b0;
        for (int k = 2; k * k <= n; k++) if (n % k == 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic load_expected();
        for (int n = 2; n <= MAX_VAL; n++) if (is_prime(n)) exp_q.push_back(n);
    endtask

    // ready pattern with irregular stalls
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            #1;
            out_ready = !((cyc % 7 == 3) || (cyc % 7 == 4) || (cyc % 11 == 0));
            cyc++;
        end
    end

    // monitor: scoreboard, stall and gap checks
    initial begin
        bit stalled = 1'b0;
        int stall_val = 0;
        bit in_gap = 1'b0;
        int gap = 0;
        int last_val = 0;
        forever begin
            @(negedge clk);
            if (run_live) begin
                if (stalled) begin
                    check(out_valid === 1'b1, "R4 valid kept", int'(out_valid), 1);
                    check(int'(out_prime) == stall_val, "R4 value kept", int'(out_prime), stall_val);
                end
                stalled = 1'b0;
                if (in_gap) begin
                    if (out_valid) begin
                        in_gap = 1'b0;
                        if (last_val == 2)
                            check(gap == HOLD, "R5 exact hold 2->3", gap, HOLD);
                        else
                            check(gap >= HOLD, "R5 minimum hold", gap, HOLD);
                    end else begin
                        gap++;
                    end
                end
                if (out_valid && out_ready) begin
                    int e;
                    e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                    if (n_accepted < 2)
                        check(int'(out_prime) == e, "R1 leading value", int'(out_prime), e);
                    else
                        check(int'(out_prime) == e, "R2 scoreboard", int'(out_prime), e);
                    for (int p = 5; p * p <= MAX_VAL; p++)
                        if (is_prime(p) && int'(out_prime) == p * p) squares_seen++;
                    n_accepted++;
                    last_val = int'(out_prime);
                    in_gap = 1'b1;
                    gap = 0;
                end else if (out_valid && !out_ready) begin
                    stalled = 1'b1;
                    stall_val = int'(out_prime);
                end
            end
        end
    end

    initial begin
        load_expected();
        fork
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                check(done === 1'b0, "R7 done low in reset", int'(done), 0);
                @(posedge clk);
                #1 rst_n = 1'b1;
                @(negedge clk);
                check(out_valid === 1'b1 && out_prime == W'(2), "R1 first value after reset",
                      int'(out_prime), 2);
                run_live = 1'b1;
                while (!done) @(negedge clk);
                check(exp_q.size() == 0, "R2 all primes emitted", exp_q.size(), 0);
                check(n_accepted == 46, "R2 prime count", n_accepted, 46);
                check(squares_seen == 0, "R3 prime squares rejected", squares_seen, 0);
                for (int i = 0; i < 12; i++) begin
                    @(negedge clk);
                    check(done === 1'b1 && out_valid === 1'b0, "R6 done sticky and silent",
                          int'(out_valid), 0);
                end
            end
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule